// File: doc/BRIEF.md
# Buffered SPI Slave

This block is an 8-bit SPI slave with a one-byte transmit holding register, a one-byte receive holding register and four status flags. The system clock oversamples the serial clock, data input and slave select through a synchronizer. Transfers run in any of the four clock polarity/phase combinations, chosen by two configuration inputs. Firmware talks to the block over a small synchronous register port. It writes the byte to send, reads the byte received and reads a status word. Reading the status word or the receive register clears the matching flags.

Slave select is active low. It comes either from a pin or from a control bit that firmware writes, and a configuration input picks the source. While the slave is deselected, it ignores the serial clock and data, resets its bit counter and holds MISO high. A queued transmit byte enters the shifter only when all three of these hold: the slave is between bytes, the shifter is free and the holding register has data. With phase 0 this load happens while idle between bytes. With phase 1 it happens on the leading clock edge of a byte's first bit.

Top module: `spi_slave_buf`

## Requirements
- R1: After reset the status word reads 0x01 (only the TX-empty flag set), MISO is 1 and the interrupt output is 0.
- R2: With `cfg_cpol`/`cfg_cpha` selecting the mode, the slave samples MOSI on the leading edge when the phase is 0 and on the trailing edge when the phase is 1. It shifts MISO on the opposite edge, most significant bit first. The byte sent equals the TX byte written and the byte received equals the master's byte.
- R3: While slave select is deasserted, MISO is 1 and SCLK/MOSI activity has no effect. No byte completes and the status stays unchanged. Deselecting in the middle of a byte discards the partial bits, so the next full byte is received intact.
- R4: When `cfg_ss_src`=0 the `ss_n` pin is the select. When it is 1, bit 0 of the control register (bus address 2, reset value 1) is the select and the pin is ignored.
- R5: A TX byte is moved into the shifter only when no byte is in progress, the shifter is empty and the TX register holds data. This happens between bytes with phase 0 and at the first leading edge of a byte with phase 1.
- R6: A TX byte written while a byte is shifting is sent as the following byte within the same selection.
- R7: If no TX byte is pending when a byte starts, the slave sends 0xFF.
- R8: On the final sampling edge of a byte, the received byte is latched into the RX register and RX-full is set. A bus read at address 0 returns the byte and clears RX-full.
- R9: If a byte completes while RX-full is still set, the overrun flag is set and the RX register holds the newer byte.
- R10: A bus read at address 1 returns {4'b0, overrun, complete, rx_full, tx_empty} in bits 7..0 and then clears the complete and overrun flags. The complete flag is set at the end of every byte.
- R11: TX-empty is cleared by a bus write at address 0 and set again when that byte is moved into the shifter.
- R12: The interrupt output is the registered OR of RX-full and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| cfg_ss_src | input | 1 | Select source: 0 pin, 1 control register bit |
| ss_n | input | 1 | Slave select pin, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 1 when idle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit data width and a two-stage synchronizer. The master's half period is eight system clocks, so each serial edge is seen several cycles after the previous one. This leaves room for the phase-0 idle-time load of a queued byte between back-to-back bytes to be observed at MISO. The same setting puts the mid-byte TX write, the transfer with no byte pending and the overrun from two unread bytes all within reach, in every mode.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic ovr;
    logic done;
    logic rx_full;
    logic tx_empty;
  } spis_stat_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spis_engine.sv
module spis_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_buf,
  input  logic              tx_valid,
  output logic              tx_take,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_d;
  logic [CNT_W-1:0]  bitcnt;
  logic              last_trail;
  logic              sh_full;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              lvl_now, lvl_old;
  logic              lead, trail, samp, shft;
  logic              idle_load;

  assign lvl_now = sclk_s ^ cpol;
  assign lvl_old = sclk_d ^ cpol;
  assign lead    = sel && lvl_now && !lvl_old;
  assign trail   = sel && !lvl_now && lvl_old;
  assign samp    = cpha ? trail : lead;
  assign shft    = cpha ? lead : trail;
  // phase 0: the byte is loaded while nothing is shifting
  assign idle_load = !cpha && !samp && !shft && (bitcnt == '0) && !last_trail
                     && !sh_full && tx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d     <= 1'b0;
      bitcnt     <= '0;
      last_trail <= 1'b0;
      sh_full    <= 1'b0;
      tx_sh      <= '1;
      rx_sh      <= '0;
      rx_byte    <= '0;
      tx_take    <= 1'b0;
      byte_done  <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      tx_take   <= 1'b0;
      byte_done <= 1'b0;
      if (!sel) begin
        bitcnt     <= '0;
        last_trail <= 1'b0;
        sh_full    <= 1'b0;
        tx_sh      <= '1;
      end else begin
        if (samp) begin
          rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
          if (bitcnt == LAST) begin
            bitcnt    <= '0;
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[DATA_W-2:0], mosi_s};
            if (cpha) sh_full    <= 1'b0;
            else      last_trail <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        if (cpha) begin
          if (shft) begin
            if (bitcnt == '0) begin
              sh_full <= 1'b1;
              if (tx_valid && !sh_full) begin
                tx_sh   <= tx_buf;
                tx_take <= 1'b1;
              end else begin
                tx_sh <= '1;
              end
            end else begin
              tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
            end
          end
        end else begin
          if (shft) begin
            if (last_trail) begin
              last_trail <= 1'b0;
              sh_full    <= 1'b0;
              tx_sh      <= '1;
            end else begin
              tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
            end
          end else if (idle_load) begin
            tx_sh   <= tx_buf;
            sh_full <= 1'b1;
            tx_take <= 1'b1;
          end
        end
      end
    end
  end

  assign miso = !sel || !sh_full || tx_sh[DATA_W-1];
endmodule

// File: rtl/spis_regs.sv
module spis_regs
  import spis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tx_take,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] tx_buf,
  output logic              tx_valid,
  output logic              fw_ss_n,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output spis_stat_t        st,
  output logic              rd_rx,
  output logic              rd_st,
  output logic              wr_tx
);
  logic [DATA_W-1:0] rx_buf;
  logic              wr_ctl;
  logic              ovr_set;

  assign rd_rx   = bus_rd && (bus_addr == A_DATA);
  assign rd_st   = bus_rd && (bus_addr == A_STAT);
  assign wr_tx   = bus_wr && (bus_addr == A_DATA);
  assign wr_ctl  = bus_wr && (bus_addr == A_CTRL);
  assign ovr_set = byte_done && st.rx_full && !rd_rx;
  assign st.tx_empty = !tx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf     <= '0;
      tx_valid   <= 1'b0;
      rx_buf     <= '0;
      st.rx_full <= 1'b0;
      st.done    <= 1'b0;
      st.ovr     <= 1'b0;
      fw_ss_n    <= 1'b1;
      bus_rdata  <= '0;
      irq        <= 1'b0;
    end else begin
      if (wr_tx) begin
        tx_buf   <= bus_wdata;
        tx_valid <= 1'b1;
      end else if (tx_take) begin
        tx_valid <= 1'b0;
      end
      if (wr_ctl) fw_ss_n <= bus_wdata[0];

      if (byte_done) begin
        rx_buf     <= rx_byte;
        st.rx_full <= 1'b1;
        st.done    <= 1'b1;
      end else begin
        if (rd_rx) st.rx_full <= 1'b0;
        if (rd_st) st.done    <= 1'b0;
      end
      if (ovr_set)    st.ovr <= 1'b1;
      else if (rd_st) st.ovr <= 1'b0;

      if (bus_rd) begin
        case (bus_addr)
          A_DATA:  bus_rdata <= rx_buf;
          A_STAT:  bus_rdata <= {{(DATA_W-STAT_W){1'b0}}, st};
          A_CTRL:  bus_rdata <= {{(DATA_W-1){1'b0}}, fw_ss_n};
          default: bus_rdata <= '0;
        endcase
      end
      irq <= st.rx_full | st.ovr;
    end
  end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
  import spis_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_ss_src,
  input  logic              ss_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              ss_s, sclk_s, mosi_s;
  logic              fw_ss_n;
  logic              sel_q;
  logic [DATA_W-1:0] tx_buf, rx_byte;
  logic              tx_valid, tx_take, byte_done;
  logic              rd_rx, rd_st, wr_tx;
  spis_stat_t        st;

  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ss_n, sclk, mosi}),
    .q   ({ss_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= !(cfg_ss_src ? fw_ss_n : ss_s);
  end

  spis_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel_q),
    .sclk_s    (sclk_s),
    .mosi_s    (mosi_s),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .tx_buf    (tx_buf),
    .tx_valid  (tx_valid),
    .tx_take   (tx_take),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (miso)
  );

  spis_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_take   (tx_take),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_buf    (tx_buf),
    .tx_valid  (tx_valid),
    .fw_ss_n   (fw_ss_n),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .st        (st),
    .rd_rx     (rd_rx),
    .rd_st     (rd_st),
    .wr_tx     (wr_tx)
  );
endmodule

// File: rtl/spis_checker.sv
module spis_checker (
  input logic clk,
  input logic rst,
  input logic sel,
  input logic miso,
  input logic byte_done,
  input logic rx_full,
  input logic ovr,
  input logic done,
  input logic tx_empty,
  input logic rd_rx,
  input logic rd_st,
  input logic wr_tx
);
  p_miso_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !sel |-> miso);

  p_rx_latch_r8: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> rx_full);

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rx_full && !rd_rx) |=> ovr);

  p_status_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_st && !byte_done) |=> !done);

  p_tx_write_r11: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !tx_empty);
endmodule

bind spi_slave_buf spis_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel_q),
  .miso      (miso),
  .byte_done (byte_done),
  .rx_full   (st.rx_full),
  .ovr       (st.ovr),
  .done      (st.done),
  .tx_empty  (st.tx_empty),
  .rd_rx     (rd_rx),
  .rd_st     (rd_st),
  .wr_tx     (wr_tx)
);

// File: tb/tb_spi_slave_buf.sv
module tb_spi_slave_buf;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_ss_src = 1'b0;
  logic       ss_n = 1'b1, sclk = 1'b0, mosi = 1'b1;
  logic       miso;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_slave_buf dut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_ss_src(cfg_ss_src), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {cpol, cpha, tx byte, mosi byte}
  localparam logic [17:0] VEC [8] = '{
    {2'b00, 8'hA5, 8'h3C}, {2'b00, 8'h01, 8'hFE},
    {2'b01, 8'h96, 8'h69}, {2'b01, 8'h80, 8'h7F},
    {2'b10, 8'hC3, 8'h0F}, {2'b10, 8'h55, 8'hAA},
    {2'b11, 8'hE7, 8'h18}, {2'b11, 8'h00, 8'hFF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cfg_cpol = pol; cfg_cpha = pha; sclk = pol;
    tick(4);
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi = mo[i];
        tick(H);
        mi[i] = miso;
        sclk = ~cfg_cpol;
        tick(H);
        sclk = cfg_cpol;
      end else begin
        tick(H);
        sclk = ~cfg_cpol;
        mosi = mo[i];
        tick(H);
        mi[i] = miso;
        sclk = cfg_cpol;
      end
    end
    tick(H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd, mi, mi2;
    tick(3);
    rst = 1'b0;
    tick(4);

    // R1 reset state; R12 interrupt low
    bus_read(2'd1, rd);
    chk("R1 status after reset", rd, 8'h01);
    chk("R1 miso idle", miso, 1'b1);
    chk("R12 irq after reset", irq, 1'b0);

    // table of mode vectors: R2, R8, R10
    for (int v = 0; v < 8; v++) begin
      set_mode(VEC[v][17], VEC[v][16]);
      bus_write(2'd0, VEC[v][15:8]);
      ss_n = 1'b0;
      tick(16);
      spi_byte(VEC[v][7:0], mi);
      ss_n = 1'b1;
      tick(8);
      chk("R2 byte on miso", mi, VEC[v][15:8]);
      bus_read(2'd1, rd);
      chk("R10 status after byte", rd, 8'h07);
      bus_read(2'd0, rd);
      chk("R8 rx byte", rd, VEC[v][7:0]);
      bus_read(2'd1, rd);
      chk("R10 status cleared", rd, 8'h01);
    end

    // R7 no byte pending, phase 0 and phase 1; R12 irq from rx_full
    set_mode(1'b0, 1'b0);
    ss_n = 1'b0; tick(16);
    spi_byte(8'h5A, mi);
    ss_n = 1'b1; tick(8);
    chk("R7 ones when empty mode0", mi, 8'hFF);
    chk("R12 irq with rx_full", irq, 1'b1);
    bus_read(2'd0, rd);
    chk("R8 rx without tx", rd, 8'h5A);
    bus_read(2'd1, rd);
    tick(3);
    chk("R12 irq cleared", irq, 1'b0);

    set_mode(1'b1, 1'b1);
    ss_n = 1'b0; tick(16);
    spi_byte(8'h24, mi);
    ss_n = 1'b1; tick(8);
    chk("R7 ones when empty mode3", mi, 8'hFF);
    bus_read(2'd0, rd);
    bus_read(2'd1, rd);

    // R6 / R11 / R5 queued byte in phase 0, then R9 overrun
    set_mode(1'b0, 1'b0);
    bus_write(2'd0, 8'h81);
    ss_n = 1'b0; tick(16);
    fork
      spi_byte(8'h11, mi);
      begin
        logic [7:0] s;
        tick(40);
        bus_write(2'd0, 8'h42);
        bus_read(2'd1, s);
        chk("R11 tx_empty cleared by write", s, 8'h00);
      end
    join
    spi_byte(8'h22, mi2);
    ss_n = 1'b1; tick(8);
    chk("R5 first byte mode0", mi, 8'h81);
    chk("R6 queued byte mode0", mi2, 8'h42);
    chk("R12 irq with overrun", irq, 1'b1);
    bus_read(2'd1, rd);
    chk("R9 overrun status", rd, 8'h0F);
    bus_read(2'd0, rd);
    chk("R9 newer byte kept", rd, 8'h22);
    bus_read(2'd1, rd);
    chk("R10 overrun cleared", rd, 8'h01);

    // R6 queued byte in phase 1
    set_mode(1'b1, 1'b1);
    bus_write(2'd0, 8'h3D);
    ss_n = 1'b0; tick(16);
    fork
      spi_byte(8'h44, mi);
      begin tick(40); bus_write(2'd0, 8'hB2); end
    join
    spi_byte(8'h55, mi2);
    ss_n = 1'b1; tick(8);
    chk("R5 first byte mode3", mi, 8'h3D);
    chk("R6 queued byte mode3", mi2, 8'hB2);
    bus_read(2'd0, rd);
    bus_read(2'd1, rd);

    // R3 deselect mid-byte and clocks while deselected
    set_mode(1'b0, 1'b0);
    ss_n = 1'b0; tick(16);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
    end
    ss_n = 1'b1; tick(8);
    chk("R3 miso high when deselected", miso, 1'b1);
    for (int i = 0; i < 8; i++) begin
      tick(H); sclk = 1'b1; tick(H); sclk = 1'b0;
    end
    tick(8);
    bus_read(2'd1, rd);
    chk("R3 no byte while deselected", rd, 8'h01);
    ss_n = 1'b0; tick(16);
    spi_byte(8'hC3, mi);
    ss_n = 1'b1; tick(8);
    bus_read(2'd0, rd);
    chk("R3 partial bits discarded", rd, 8'hC3);
    bus_read(2'd1, rd);

    // R4 firmware select source
    cfg_ss_src = 1'b1;
    ss_n = 1'b0; tick(16);
    spi_byte(8'h99, mi);
    tick(8);
    chk("R4 pin ignored miso", mi, 8'hFF);
    bus_read(2'd1, rd);
    chk("R4 pin ignored status", rd, 8'h01);
    ss_n = 1'b1;
    bus_write(2'd0, 8'h6E);
    bus_write(2'd2, 8'h00);
    tick(16);
    spi_byte(8'h17, mi);
    bus_write(2'd2, 8'h01);
    tick(8);
    chk("R4 fw select byte out", mi, 8'h6E);
    bus_read(2'd0, rd);
    chk("R4 fw select byte in", rd, 8'h17);
    bus_read(2'd1, rd);
    chk("R11 tx_empty after load", rd[0], 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule